// File: doc/BRIEF.md
# Real-Time Clock Update Sequencer and Interrupt Controller

This block paces the once-per-second refresh of a real-time clock and turns clock events into an interrupt request. A one-cycle `sec_tick` from the divider opens an update window. `uip` rises at once and stays high for a lead interval of `LEAD_TICKS` base-clock ticks. At the end of that interval `adv_stb` tells the timekeeping logic to advance its internal copy of the time. The update itself then runs for `UPD_TICKS` base ticks. When it ends, `uip` drops, the update-complete flag is raised, and `copy_stb` tells the register file to copy the ten time, alarm and calendar bytes into the host-visible buffer. A host-controlled inhibit bit suppresses only that copy: the internal copy keeps advancing, and the host sees frozen values until the bit is cleared.

Three event flags are held in a flag register: update-complete, alarm match and periodic rate. Each has its own enable in a control register. An enabled pending flag drives `irq_oe`, which is the pull-down enable of an open-drain interrupt line. A host read of the flag register returns the flags and clears them all, which releases the line.

The sequencer is a three-state machine:
- IDLE waits for `sec_tick`.
- IDLE→LEAD is taken on `sec_tick`.
- LEAD counts lead ticks.
- LEAD→UPDATE is taken on the last lead tick and pulses `adv_stb`.
- UPDATE counts update ticks.
- UPDATE→IDLE is taken on the last update tick. It ends the cycle, sets the update-complete flag and, when the inhibit bit is clear, pulses `copy_stb`.

Top module: `rtc_upd_irq`

## Requirements
- R1: After reset, `uip`, `adv_stb`, `copy_stb` and `irq_oe` are 0, `flag_rdata` reads 0, and all control bits are 0.
- R2: A `sec_tick` seen in IDLE sets `uip` on the next clock edge. `adv_stb` pulses for one cycle on the edge that consumes the `LEAD_TICKS`-th `base_tick` after that.
- R3: On the edge that consumes the `UPD_TICKS`-th `base_tick` of the update, `uip` clears and the update-complete flag (`flag_rdata` bit 0) sets.
- R4: While the inhibit bit (control bit 3) is 1, an update still pulses `adv_stb` but never pulses `copy_stb`.
- R5: While the inhibit bit is 0, `copy_stb` pulses for exactly one cycle on the edge that ends the update.
- R6: `irq_oe` is 1 exactly when some flag is set and its enable is set. The flags are: update-complete at bit 0, alarm at bit 1, periodic at bit 2. The enables are control bits 0, 1 and 2 in the same order. `flag_rdata` bit 3 mirrors this summary.
- R7: A `flag_rd` cycle returns the current flags on `flag_rdata` and clears all three flags on its edge, so `irq_oe` goes to 0 on the next cycle.
- R8: A flag whose set event falls in the same cycle as `flag_rd` stays set after the read.
- R9: While `rst_n` is low, `irq_oe` is 0.
- R10: A `sec_tick` that arrives while `uip` is 1 is ignored. It neither lengthens the window nor starts a second update.
- R11: `alarm_hit` and `per_hit` set their flags whatever the enables hold. A flag that is set but disabled does not drive `irq_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | One-cycle enable per 32.768 kHz base period |
| sec_tick | input | 1 | One-cycle pulse that opens the update window |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | Control data: bit 0 update enable, bit 1 alarm enable, bit 2 periodic enable, bit 3 transfer inhibit |
| flag_rd | input | 1 | Flag register read strobe (clears the flags) |
| alarm_hit | input | 1 | Alarm match event pulse |
| per_hit | input | 1 | Periodic rate event pulse |
| uip | output | 1 | Update-in-progress status |
| flag_rdata | output | 4 | Flag read data: {irq summary, periodic, alarm, update-complete} |
| irq_oe | output | 1 | Pull-down enable of the open-drain interrupt |
| adv_stb | output | 1 | Advance the internal time copy |
| copy_stb | output | 1 | Copy internal bytes to the host buffer |

## Verification
The interrupt merge is driven through a table of enable masks crossed with alarm and periodic pulses. The table includes a set flag whose enable is clear, a set enable with no flag, and a mix of both, so that a wrong bit mapping or a missing gate changes the result. Full update cycles are run with the inhibit bit clear and with it set. In each run the tick on which `adv_stb`, the fall of `uip` and `copy_stb` appear is compared, which separates off-by-one lead or update counts and a copy that ignores the inhibit. Other directed cases cover a second `sec_tick` inside the window, a read that coincides with a new event, and an interrupt pending when reset is asserted.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_LEAD   = 2'd1,
        SEQ_UPDATE = 2'd2
    } seq_state_e;

    localparam int NUM_SRC = 3;  // update-complete, alarm, periodic

    typedef struct packed {
        logic uti;   // bit 3: freeze host buffer
        logic pie;   // bit 2: periodic enable
        logic aie;   // bit 1: alarm enable
        logic uie;   // bit 0: update-complete enable
    } ctrl_t;
endpackage

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq
    import rtc_upd_pkg::*;
#(
    parameter int LEAD_TICKS = 8,
    parameter int UPD_TICKS  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic base_tick,
    input  logic sec_tick,
    input  logic uti,
    output logic uip,
    output logic adv_stb,
    output logic copy_stb,
    output logic upd_end
);
    localparam int MAXT = (LEAD_TICKS > UPD_TICKS) ? LEAD_TICKS : UPD_TICKS;
    localparam int CW   = (MAXT > 1) ? $clog2(MAXT) : 1;
    localparam logic [CW-1:0] LEAD_LAST = CW'(LEAD_TICKS - 1);
    localparam logic [CW-1:0] UPD_LAST  = CW'(UPD_TICKS - 1);

    seq_state_e    state, state_n;
    logic [CW-1:0] cnt, cnt_n;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            SEQ_IDLE: begin
                if (sec_tick) begin
                    state_n = SEQ_LEAD;
                    cnt_n   = '0;
                end
            end
            SEQ_LEAD: begin
                if (base_tick) begin
                    if (cnt == LEAD_LAST) begin
                        state_n = SEQ_UPDATE;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + CW'(1);
                    end
                end
            end
            SEQ_UPDATE: begin
                if (base_tick) begin
                    if (cnt == UPD_LAST) begin
                        state_n = SEQ_IDLE;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + CW'(1);
                    end
                end
            end
            default: begin
                state_n = SEQ_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    assign upd_end = (state == SEQ_UPDATE) && (state_n == SEQ_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uip      <= 1'b0;
            adv_stb  <= 1'b0;
            copy_stb <= 1'b0;
        end else begin
            uip      <= (state_n != SEQ_IDLE);
            adv_stb  <= (state == SEQ_LEAD) && (state_n == SEQ_UPDATE);
            copy_stb <= upd_end && !uti;
        end
    end
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
    import rtc_upd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [3:0] ctrl_wdata,
    input  logic       flag_rd,
    input  logic       upd_end,
    input  logic       alarm_hit,
    input  logic       per_hit,
    output ctrl_t      ctrl,
    output logic [3:0] flag_rdata,
    output logic       irq_oe
);
    logic [NUM_SRC-1:0] flg;
    logic [NUM_SRC-1:0] set_ev;
    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] pend;

    assign set_ev = {per_hit, alarm_hit, upd_end};
    assign en     = {ctrl.pie, ctrl.aie, ctrl.uie};

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            assign pend[g] = flg[g] & en[g];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg  <= '0;
            ctrl <= '0;
        end else begin
            if (ctrl_we) ctrl <= ctrl_t'(ctrl_wdata);
            flg <= (flag_rd ? '0 : flg) | set_ev;
        end
    end

    assign flag_rdata = {|pend, flg};
    assign irq_oe     = rst_n & (|pend);
endmodule

// File: rtl/rtc_upd_irq.sv
module rtc_upd_irq
    import rtc_upd_pkg::*;
#(
    parameter int LEAD_TICKS = 8,
    parameter int UPD_TICKS  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_tick,
    input  logic       sec_tick,
    input  logic       ctrl_we,
    input  logic [3:0] ctrl_wdata,
    input  logic       flag_rd,
    input  logic       alarm_hit,
    input  logic       per_hit,
    output logic       uip,
    output logic [3:0] flag_rdata,
    output logic       irq_oe,
    output logic       adv_stb,
    output logic       copy_stb
);
    ctrl_t ctrl_q;
    logic  uti_w;
    logic  upd_end;

    assign uti_w = ctrl_q.uti;

    rtc_upd_seq #(
        .LEAD_TICKS(LEAD_TICKS),
        .UPD_TICKS (UPD_TICKS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_tick(base_tick),
        .sec_tick (sec_tick),
        .uti      (uti_w),
        .uip      (uip),
        .adv_stb  (adv_stb),
        .copy_stb (copy_stb),
        .upd_end  (upd_end)
    );

    rtc_irq_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (ctrl_we),
        .ctrl_wdata(ctrl_wdata),
        .flag_rd   (flag_rd),
        .upd_end   (upd_end),
        .alarm_hit (alarm_hit),
        .per_hit   (per_hit),
        .ctrl      (ctrl_q),
        .flag_rdata(flag_rdata),
        .irq_oe    (irq_oe)
    );
endmodule

// File: rtl/rtc_upd_irq_chk.sv
module rtc_upd_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       flag_rd,
    input logic       alarm_hit,
    input logic       per_hit,
    input logic       uip,
    input logic       adv_stb,
    input logic       copy_stb,
    input logic       irq_oe,
    input logic       upd_end,
    input logic       ctrl_uti,
    input logic [3:0] flag_rdata
);
    p_uip_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uip) |-> $past(sec_tick));

    p_adv_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adv_stb |-> uip);

    p_end_sets_uf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uip) |-> flag_rdata[0]);

    p_inhibit_no_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        copy_stb |-> !$past(ctrl_uti));

    p_copy_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        copy_stb |-> !uip);

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !alarm_hit && !per_hit && !upd_end) |=> (flag_rdata == 4'b0000));

    p_keep_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && alarm_hit) |=> flag_rdata[1]);

    always_comb begin
        if (!rst_n) begin
            p_irq_quiet_r9: assert (!irq_oe);
        end
    end
endmodule

bind rtc_upd_irq rtc_upd_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .flag_rd   (flag_rd),
    .alarm_hit (alarm_hit),
    .per_hit   (per_hit),
    .uip       (uip),
    .adv_stb   (adv_stb),
    .copy_stb  (copy_stb),
    .irq_oe    (irq_oe),
    .upd_end   (upd_end),
    .ctrl_uti  (uti_w),
    .flag_rdata(flag_rdata)
);

// File: tb/rtc_upd_irq_tb.sv
module rtc_upd_irq_tb;
    localparam int LEAD = 3;
    localparam int UPD  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0, sec_tick = 1'b0, ctrl_we = 1'b0, flag_rd = 1'b0;
    logic       alarm_hit = 1'b0, per_hit = 1'b0;
    logic [3:0] ctrl_wdata = 4'h0;
    logic       uip, irq_oe, adv_stb, copy_stb;
    logic [3:0] flag_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_upd_irq #(.LEAD_TICKS(LEAD), .UPD_TICKS(UPD)) u_dut (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .sec_tick(sec_tick),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .flag_rd(flag_rd),
        .alarm_hit(alarm_hit), .per_hit(per_hit), .uip(uip),
        .flag_rdata(flag_rdata), .irq_oe(irq_oe), .adv_stb(adv_stb),
        .copy_stb(copy_stb)
    );

    typedef struct packed {
        logic [2:0] en;   // {pie, aie, uie}
        logic [1:0] ev;   // {per_hit, alarm_hit}
        logic [2:0] fl;   // expected {pf, af, uf}
        logic       irq;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{3'b000, 2'b11, 3'b110, 1'b0},
        '{3'b010, 2'b01, 3'b010, 1'b1},
        '{3'b100, 2'b01, 3'b010, 1'b0},
        '{3'b100, 2'b10, 3'b100, 1'b1},
        '{3'b001, 2'b11, 3'b110, 1'b0},
        '{3'b110, 2'b00, 3'b000, 1'b0},
        '{3'b111, 2'b10, 3'b100, 1'b1},
        '{3'b011, 2'b10, 3'b100, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [3:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic clear_flags();
        flag_rd = 1'b1;
        @(negedge clk);
        flag_rd = 1'b0;
    endtask

    task automatic run_update(input bit exp_copy, input bit retick);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        chk("R2 uip set after sec_tick", int'(uip), 1);
        for (int i = 0; i < LEAD; i++) begin
            base_tick = 1'b1;
            if (retick && i == 0) sec_tick = 1'b1;
            @(negedge clk);
            base_tick = 1'b0; sec_tick = 1'b0;
            if (i == LEAD - 1) chk("R2 adv_stb on last lead tick", int'(adv_stb), 1);
            else               chk("R2 adv_stb quiet during lead", int'(adv_stb), 0);
        end
        for (int i = 0; i < UPD; i++) begin
            base_tick = 1'b1;
            @(negedge clk);
            base_tick = 1'b0;
            if (i == UPD - 1) begin
                chk("R3 uip clears at end", int'(uip), 0);
                chk("R3 uf set at end", int'(flag_rdata[0]), 1);
                chk(exp_copy ? "R5 copy_stb at end" : "R4 no copy while inhibited",
                    int'(copy_stb), int'(exp_copy));
            end else begin
                chk(retick ? "R10 window not extended" : "R3 uip held in update",
                    int'(uip), 1);
            end
        end
        @(negedge clk);
        chk("R5 copy_stb one cycle", int'(copy_stb), 0);
        if (retick) begin
            for (int i = 0; i < LEAD + UPD + 2; i++) begin
                base_tick = 1'b1;
                @(negedge clk);
                base_tick = 1'b0;
            end
            chk("R10 no second update", int'(uip), 0);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        chk("R9 irq quiet in reset", int'(irq_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 uip", int'(uip), 0);
        chk("R1 flags", int'(flag_rdata), 0);
        chk("R1 irq", int'(irq_oe), 0);
        chk("R1 strobes", int'({adv_stb, copy_stb}), 0);

        // R6 / R11 table of enables and events
        foreach (VEC[k]) begin
            ctrl_we = 1'b1; ctrl_wdata = {1'b0, VEC[k].en};
            flag_rd = 1'b1;
            @(negedge clk);
            ctrl_we = 1'b0; flag_rd = 1'b0;
            per_hit = VEC[k].ev[1]; alarm_hit = VEC[k].ev[0];
            @(negedge clk);
            per_hit = 1'b0; alarm_hit = 1'b0;
            chk("R11 flags set regardless of enable", int'(flag_rdata[2:0]), int'(VEC[k].fl));
            chk("R6 irq merge", int'(irq_oe), int'(VEC[k].irq));
            chk("R6 summary bit", int'(flag_rdata[3]), int'(VEC[k].irq));
        end

        // Update with inhibit clear, uie enabled
        wr_ctrl(4'b0001);
        clear_flags();
        run_update(1'b1, 1'b0);
        chk("R6 uf raises irq", int'(irq_oe), 1);

        // R7 read returns then clears
        flag_rd = 1'b1;
        #1;
        chk("R7 read data before clear", int'(flag_rdata), 9);
        @(negedge clk);
        flag_rd = 1'b0;
        chk("R7 flags cleared", int'(flag_rdata), 0);
        chk("R7 irq released", int'(irq_oe), 0);

        // R4 inhibit set
        wr_ctrl(4'b1001);
        run_update(1'b0, 1'b0);
        clear_flags();

        // R10 second tick inside window
        wr_ctrl(4'b0000);
        run_update(1'b1, 1'b1);

        // R8 set event coincident with read
        wr_ctrl(4'b0010);
        clear_flags();
        flag_rd = 1'b1; alarm_hit = 1'b1;
        @(negedge clk);
        flag_rd = 1'b0; alarm_hit = 1'b0;
        chk("R8 alarm kept across read", int'(flag_rdata[1]), 1);
        chk("R8 irq still pending", int'(irq_oe), 1);

        // R9 reset with pending interrupt
        rst_n = 1'b0;
        #1;
        chk("R9 irq released by reset", int'(irq_oe), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flags cleared by reset", int'(flag_rdata), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule